// File: doc/BRIEF.md
# Dithered Flyback PWM Controller

This block drives the primary switch of an isolated flyback converter from a digital compensation code. Each switching period is sized at its first cycle: a nominal count, taken from the system clock and the switching frequency, is moved by a pseudo-random offset of at most six percent either way. This spreads the switching spectrum. The on-time for that period is the compensation code scaled into a window that ends at 55% of the chosen period length. The converter therefore stays in discontinuous conduction however far the code rises.

The protection inputs arrive as flags from comparators outside the block. A primary overcurrent flag drops the gate in the same cycle and keeps it low until the next period begins. A secondary overvoltage flag stops switching while it is high. After it falls, switching stays stopped for one more nominal period. A supply-good flag must be high before any period can start. The block is a thin top around a control module, which handles gating and protection state, and a datapath module, which holds the period counter, the dither generator and the on-time arithmetic.

Top module: `flyback_pwm`

## Requirements
- R1: While reset (`rstN`) is low, `swGate` is low. After release, the dither register holds 16'hACE1 and no period is running, so the gate stays low until a period starts.
- R2: A period starts on the first clock edge at which the block is not blocked (supply good, no overvoltage flag, no overvoltage wait) and either no period is running or the running one is on its last cycle. From that edge the counter runs 0 to len-1, and `swGate` is high while count < onTime.
- R3: The period length is NOM - DITH + (L mod (2*DITH+1)). L is the dither register value at the start edge, NOM = CLK_HZ/SW_HZ and DITH = NOM*DITHER_PCT/100. The length therefore always lies within NOM±DITH (200±12 at the defaults).
- R4: The dither register advances once per period start. The next value is {L[14:0], L[15]^L[13]^L[12]^L[10]}.
- R5: onTime = (compCode * cap) >> COMP_W, where cap = len*DUTY_PCT/100 (DUTY_PCT defaults to 55). compCode is sampled at the start edge. A code of 0 gives no pulse, and no pulse ever reaches cap.
- R6: `swGate` is low in any cycle where `ocFlag` is high. Once `ocFlag` is seen high during a running period, the gate stays low for the rest of that period, and the next period starts with the cutoff cleared.
- R7: `swGate` is low while `ovFlag` is high, and the running period is abandoned. After `ovFlag` falls, no period starts until NOM further clock edges have passed.
- R8: While `supplyOk` is low, `swGate` is low and the running period is abandoned. The next start follows the rule of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Input supply above its turn-on threshold |
| ovFlag | input | 1 | Secondary overvoltage comparator |
| ocFlag | input | 1 | Primary overcurrent comparator |
| compCode | input | COMP_W | Sampled compensation code; larger means longer on-time |
| swGate | output | 1 | Primary switch gate drive |

## Verification
The bench goes after the points where a period restarts. A restart can follow the last count, an overcurrent cutoff late in a period, the end of an overvoltage wait, or a supply dip. Each of these is a place where an off-by-one in the wait counter or the start rule would shift every later edge. It also drives the compensation code to full scale, where a cap worked out from the nominal period instead of the dithered one would push the pulse past 55% on short periods. A dither offset worked out with the wrong modulus shows up as a measured period outside ±6%. An overcurrent cutoff that is not latched shows up as the gate coming back on within the same period.

// File: rtl/flyback_pkg.sv
package flyback_pkg;
  typedef struct packed {
    logic start;   // begin a new period this edge
    logic advance; // period running, step the counter
  } ctrlStrobe_t;

  localparam logic [15:0] DITHER_SEED = 16'hACE1;

  function automatic logic [15:0] ditherNext(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/fb_datapath.sv
module fb_datapath
  import flyback_pkg::*;
#(
  parameter int CLK_HZ     = 12_000_000,
  parameter int SW_HZ      = 60_000,
  parameter int DITHER_PCT = 6,
  parameter int DUTY_PCT   = 55,
  parameter int COMP_W     = 8,
  localparam int NOM   = CLK_HZ / SW_HZ,
  localparam int DITH  = NOM * DITHER_PCT / 100,
  localparam int SPAN  = 2 * DITH + 1,
  localparam int CNT_W = $clog2(NOM + DITH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [COMP_W-1:0] compCode,
  output logic              lastCycle,
  output logic              onActive,
  output logic [CNT_W-1:0]  periodLen,
  output logic [CNT_W-1:0]  onTime
);
  localparam int CAP_W = CNT_W + 7;
  localparam int PRD_W = CNT_W + COMP_W;

  logic [15:0]      dither;
  logic [CNT_W-1:0] count;
  logic [15:0]      pick;
  logic [CNT_W-1:0] lenNext;
  logic [CAP_W-1:0] capWide;
  logic [PRD_W-1:0] product;
  logic [CNT_W-1:0] onNext;

  always_comb begin
    pick    = dither % 16'(SPAN);
    lenNext = CNT_W'(NOM - DITH) + CNT_W'(pick);
    capWide = ({7'd0, lenNext} * CAP_W'(DUTY_PCT)) / CAP_W'(100);
    product = {{COMP_W{1'b0}}, capWide[CNT_W-1:0]} * {{CNT_W{1'b0}}, compCode};
    onNext  = product[COMP_W +: CNT_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dither    <= DITHER_SEED;
      count     <= '0;
      periodLen <= CNT_W'(NOM);
      onTime    <= '0;
    end else if (strobe.start) begin
      dither    <= ditherNext(dither);
      count     <= '0;
      periodLen <= lenNext;
      onTime    <= onNext;
    end else if (strobe.advance) begin
      count <= count + 1'b1;
    end else begin
      count <= '0;
    end
  end

  assign lastCycle = (count == periodLen - 1'b1);
  assign onActive  = (count < onTime);
endmodule

// File: rtl/fb_control.sv
module fb_control
  import flyback_pkg::*;
#(
  parameter int NOM = 200,
  localparam int OV_W = $clog2(NOM + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        ovFlag,
  input  logic        ocFlag,
  input  logic        lastCycle,
  input  logic        onActive,
  output ctrlStrobe_t strobe,
  output logic        ocLatch,
  output logic        swGate
);
  logic            running;
  logic [OV_W-1:0] ovWait;
  logic            blocked;

  assign blocked        = !supplyOk || ovFlag || (ovWait != '0);
  assign strobe.start   = !blocked && (!running || lastCycle);
  assign strobe.advance = running && !blocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      ocLatch <= 1'b0;
      ovWait  <= '0;
    end else begin
      running <= !blocked;
      if (strobe.start || blocked) ocLatch <= 1'b0;
      else if (ocFlag && running)  ocLatch <= 1'b1;
      if (ovFlag)               ovWait <= OV_W'(NOM);
      else if (ovWait != '0)    ovWait <= ovWait - 1'b1;
    end
  end

  assign swGate = running && onActive && !ocLatch && !ocFlag && !blocked;
endmodule

// File: rtl/flyback_pwm.sv
module flyback_pwm
  import flyback_pkg::*;
#(
  parameter int CLK_HZ     = 12_000_000,
  parameter int SW_HZ      = 60_000,
  parameter int DITHER_PCT = 6,
  parameter int DUTY_PCT   = 55,
  parameter int COMP_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyOk,
  input  logic              ovFlag,
  input  logic              ocFlag,
  input  logic [COMP_W-1:0] compCode,
  output logic              swGate
);
  localparam int NOM   = CLK_HZ / SW_HZ;
  localparam int DITH  = NOM * DITHER_PCT / 100;
  localparam int CNT_W = $clog2(NOM + DITH + 1);

  ctrlStrobe_t      strobe;
  logic             lastCycle;
  logic             onActive;
  logic             ocLatch;
  logic [CNT_W-1:0] periodLen;
  logic [CNT_W-1:0] onTime;

  fb_control #(.NOM(NOM)) u_ctrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .ovFlag(ovFlag),
    .ocFlag(ocFlag), .lastCycle(lastCycle), .onActive(onActive),
    .strobe(strobe), .ocLatch(ocLatch), .swGate(swGate)
  );

  fb_datapath #(
    .CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ), .DITHER_PCT(DITHER_PCT),
    .DUTY_PCT(DUTY_PCT), .COMP_W(COMP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .compCode(compCode),
    .lastCycle(lastCycle), .onActive(onActive),
    .periodLen(periodLen), .onTime(onTime)
  );
endmodule

// File: rtl/flyback_pwm_checker.sv
module flyback_pwm_checker #(
  parameter int NOM   = 200,
  parameter int DITH  = 12,
  parameter int DUTY  = 55,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             supplyOk,
  input logic             ovFlag,
  input logic             ocFlag,
  input logic             ocLatch,
  input logic             swGate,
  input logic [CNT_W-1:0] periodLen,
  input logic [CNT_W-1:0] onTime
);
  p_oc_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    ocFlag |-> !swGate);
  p_oc_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ocLatch |-> !swGate);
  p_ov_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovFlag |-> !swGate);
  p_ov_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovFlag) |-> !swGate);
  p_supply_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> !swGate);
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(periodLen) >= NOM - DITH) && (int'(periodLen) <= NOM + DITH));
  p_duty_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    int'(onTime) * 100 < int'(periodLen) * DUTY);
endmodule

bind flyback_pwm flyback_pwm_checker #(
  .NOM(NOM), .DITH(DITH), .DUTY(DUTY_PCT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .ovFlag(ovFlag),
  .ocFlag(ocFlag), .ocLatch(ocLatch), .swGate(swGate),
  .periodLen(periodLen), .onTime(onTime)
);

// File: tb/flyback_pwm_test.sv
module flyback_pwm_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 12_000_000;
  localparam int SW_HZ  = 60_000;
  localparam int NOM    = CLK_HZ / SW_HZ;
  localparam int DITH   = NOM * 6 / 100;
  localparam int DUTY   = 55;
  localparam int CW     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic ovFlag = 1'b0;
  logic ocFlag = 1'b0;
  logic [CW-1:0] compCode = '0;
  logic swGate;

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  // reference state
  bit mRun, mOc;
  int mCnt, mLen, mOnT, mOvWait;
  logic [15:0] mDither;
  // period measurement
  int lastRise, highLen;
  bit prevGate;

  always #(CLK_PERIOD/2) clk = ~clk;

  flyback_pwm #(.CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ), .DITHER_PCT(6),
    .DUTY_PCT(DUTY), .COMP_W(CW)) uut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .ovFlag(ovFlag),
    .ocFlag(ocFlag), .compCode(compCode), .swGate(swGate));

  function automatic logic [15:0] stepDither(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int lenFor(input logic [15:0] s);
    return NOM - DITH + int'(s % 16'(2*DITH+1));
  endfunction

  function automatic int onFor(input int len, input int code);
    return (code * (len * DUTY / 100)) >> CW;
  endfunction

  function automatic bit isBlocked();
    return !supplyOk || ovFlag || (mOvWait != 0);
  endfunction

  function automatic bit expGate();
    return mRun && (mCnt < mOnT) && !mOc && !ocFlag && !isBlocked();
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: swGate=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    bit blk, st;
    blk = isBlocked();
    st  = !blk && (!mRun || (mCnt == mLen - 1));
    if (st || blk) mOc = 1'b0; else if (ocFlag && mRun) mOc = 1'b1;
    if (st) begin
      mLen = lenFor(mDither);
      mOnT = onFor(mLen, int'(compCode));
      mDither = stepDither(mDither);
      mCnt = 0;
    end else if (mRun && !blk) mCnt++;
    else mCnt = 0;
    mRun = !blk;
    if (ovFlag) mOvWait = NOM; else if (mOvWait != 0) mOvWait--;
  endtask

  // one cycle: inputs already set at negedge; compare then advance
  task automatic cycle(input string tag, input int cyc);
    bit g;
    #1;
    g = swGate;
    check(tag, g, expGate());
    if (g && !prevGate) begin
      if (lastRise >= 0 && (cyc - lastRise) <= NOM + DITH + 1
          && tag == "R3") begin
        vectors++;
        if ((cyc - lastRise) < NOM - DITH || (cyc - lastRise) > NOM + DITH) begin
          misses++;
          $display("FAIL R3: rise spacing %0d expected %0d..%0d",
                   cyc - lastRise, NOM - DITH, NOM + DITH);
        end
      end
      lastRise = cyc;
      highLen = 0;
    end
    if (g) highLen++;
    if (!g && prevGate && tag == "R5") begin
      vectors++;
      if (highLen * 100 >= (NOM + DITH) * DUTY) begin
        misses++;
        $display("FAIL R5: pulse %0d cycles expected below %0d",
                 highLen, (NOM + DITH) * DUTY / 100);
      end
    end
    prevGate = g;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  initial begin
    int seedSink;
    int cyc;
    seedSink = $urandom(32'd1234);
    lastRise = -1; highLen = 0; prevGate = 0; cyc = 0;
    mRun = 0; mOc = 0; mCnt = 0; mLen = NOM; mOnT = 0; mOvWait = 0;
    mDither = 16'hACE1;
    supplyOk = 1'b1; compCode = 8'd128;
    // R1: reset holds the gate low
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      check("R1", swGate, 1'b0);
    end
    @(negedge clk); rstN = 1'b1;
    // R2/R4: steady running with a fixed code
    for (int i = 0; i < 1200; i++) begin cycle("R2", cyc); cyc++; end
    // R3: period spacing under full code, random updates
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) compCode = 8'($urandom_range(64, 255));
      cycle("R3", cyc); cyc++;
    end
    // R5: cap at full scale and zero code
    compCode = 8'd255;
    for (int i = 0; i < 2000; i++) begin cycle("R5", cyc); cyc++; end
    compCode = 8'd0;
    for (int i = 0; i < 450; i++) begin cycle("R5", cyc); cyc++; end
    compCode = 8'd200;
    // R6: overcurrent pulses, short and late in period
    for (int i = 0; i < 4000; i++) begin
      ocFlag = ($urandom_range(0, 99) < 3);
      cycle("R6", cyc); cyc++;
    end
    ocFlag = 1'b0;
    // R7: overvoltage bursts and recovery wait
    for (int k = 0; k < 6; k++) begin
      int hold = $urandom_range(1, 40);
      int gap  = (k == 0) ? NOM - 1 : $urandom_range(NOM, 3 * NOM);
      for (int i = 0; i < gap; i++) begin cycle("R7", cyc); cyc++; end
      ovFlag = 1'b1;
      for (int i = 0; i < hold; i++) begin cycle("R7", cyc); cyc++; end
      ovFlag = 1'b0;
    end
    for (int i = 0; i < 2 * NOM + 10; i++) begin cycle("R7", cyc); cyc++; end
    // R8: supply dips, including single-cycle drops
    for (int i = 0; i < 3000; i++) begin
      if (i % 311 == 0) supplyOk = 1'b0;
      else if (!supplyOk && $urandom_range(0, 9) < 4) supplyOk = 1'b1;
      cycle("R8", cyc); cyc++;
    end
    supplyOk = 1'b1;
    // mixed random
    for (int i = 0; i < 6000; i++) begin
      compCode = (i % 53 == 0) ? 8'($urandom) : compCode;
      ocFlag   = ($urandom_range(0, 199) == 0);
      ovFlag   = ($urandom_range(0, 999) == 0);
      supplyOk = ($urandom_range(0, 499) != 0);
      cycle("R2", cyc); cyc++;
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule